// File: doc/BRIEF.md
# In-Order Retire Slot Controller

This block keeps the slot accounting of a reorder buffer. When an instruction is dispatched, the block reserves a run of consecutive slots for it and hands back a token. The token is the slot position where that run starts. When write-back finishes, the token is marked executed. On each cycle tick the block walks the live tokens from the oldest one. It retires every executed token it meets, in program order, and stops at the first token that has not executed. The slots of each retired token go back to the free pool, and the instruction index of each retired token is reported on an ordered set of retire lanes.

One instruction may occupy several slots. A request larger than the whole buffer is cut down to the buffer size, so that it can still be dispatched into an empty buffer. A request of zero micro-ops takes one slot. A retire limit input caps how many tokens may leave on one tick, and the value zero removes the cap. The block stores no result values and has no flush path.

Top module: `retire_slot_ctrl`

## Requirements
- R1: After reset the buffer reports empty (`bufEmpty`=1, `bufFull`=0), the next token offered is slot 0, and all retire lanes are idle.
- R2: A reservation is granted (`rsvAccept`=1) when `rsvValid` is high and `rsvAvail` is high. The token returned in that cycle on `rsvToken` is the position of the first reserved slot. The next token position is that position plus the reserved slot count, modulo `SLOTS`.
- R3: The reserved slot count is `rsvUops` when it lies in 1..`SLOTS`. It is 1 when `rsvUops` is 0, and it is `SLOTS` when `rsvUops` exceeds `SLOTS`. `rsvAvail` is high exactly when this capped count does not exceed the free slot count.
- R4: A request with `rsvAvail` low is ignored. `rsvAccept` stays low and the next offered token does not change.
- R5: `exeValid` marks the token whose first slot is `exeToken` as executed. A position that is not the first slot of a live token is ignored, and nothing can later retire because of it.
- R6: On a cycle with `tick` high, live tokens retire strictly oldest first. Only executed tokens retire, and the first token that has not executed ends retirement for that tick. No tick means no retirement.
- R7: With `retireLimit` nonzero, at most that many tokens retire on one tick. With `retireLimit` zero, there is no cap.
- R8: The retirements of a tick appear in the cycle after the tick edge. Lane k (`retValid[k]`, `retIndex[k*IDX_W +: IDX_W]`) carries the k-th token retired, in program order. The valid lanes form a contiguous run from lane 0. All lanes are idle in a cycle that follows no tick.
- R9: Retiring a token returns its reserved slot count to the free pool. `bufFull` is high when no slot is free, and `bufEmpty` is high when all `SLOTS` slots are free.
- R10: When a reservation and retirements happen in the same cycle, `rsvAvail` is judged against the free count at the start of that cycle. The new free count is the old count plus the retired slots minus the reserved slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Cycle event that allows retirement |
| retireLimit | input | CNT_W | Maximum retirements per tick; 0 = no cap |
| rsvValid | input | 1 | Reservation request |
| rsvUops | input | UOP_W | Micro-op count of the request |
| rsvIndex | input | IDX_W | Instruction index stored with the token |
| rsvAvail | output | 1 | Capped request fits in the free slots |
| rsvAccept | output | 1 | Reservation granted this cycle |
| rsvToken | output | PTR_W | Token (first slot position) for the request |
| exeValid | input | 1 | Write-back notification |
| exeToken | input | PTR_W | Token being marked executed |
| retValid | output | SLOTS | Per-lane retire valid, lane 0 oldest |
| retIndex | output | SLOTS*IDX_W | Per-lane retired instruction index |
| bufFull | output | 1 | No slot free |
| bufEmpty | output | 1 | All slots free |

## Verification
`rsvAvail`, `rsvAccept` and `rsvToken` are combinational on the current state. The bench drives a request on the falling edge and reads these three outputs shortly after, before the rising edge. The token offered after a grant is read one edge later. The retire lanes, the free-count flags and executed marks are registered. The lanes and flags are therefore sampled at the falling edge after the tick's rising edge. An executed mark only affects a tick at least one edge later, so the mark on a token and its retirement never share an edge in the expected values.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  // Strobes from the slot control to the token table.
  typedef struct packed {
    logic tokWrite;   // store a new token at the write position
    logic exeMark;    // set the executed flag of a live token
  } rsc_strobe_t;

endpackage

// File: rtl/rsc_retire_ctrl.sv
module rsc_retire_ctrl
  import rsc_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int UOP_W = 8,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tick,
  input  logic [CNT_W-1:0]         retireLimit,
  input  logic                     rsvValid,
  input  logic [UOP_W-1:0]         rsvUops,
  input  logic                     exeValid,
  input  logic [PTR_W-1:0]         exeToken,
  input  logic [SLOTS-1:0]         tokValid,
  input  logic [SLOTS-1:0]         tokExec,
  input  logic [SLOTS*CNT_W-1:0]   tokLen,
  output rsc_strobe_t              strb,
  output logic [PTR_W-1:0]         wrPos,
  output logic [CNT_W-1:0]         wrLen,
  output logic [PTR_W-1:0]         exePos,
  output logic [SLOTS-1:0]         clrMask,
  output logic [SLOTS*PTR_W-1:0]   lanePos,
  output logic [SLOTS-1:0]         laneFire,
  output logic                     rsvAvail,
  output logic                     rsvAccept,
  output logic [PTR_W-1:0]         rsvToken,
  output logic                     bufFull,
  output logic                     bufEmpty
);

  logic [PTR_W-1:0] headQ, tailQ, headNext;
  logic [CNT_W-1:0] freeQ, freedSum, capLen;
  logic [CNT_W:0]   freeSum;

  // Circular add of a slot count to a slot position.
  function automatic logic [PTR_W-1:0] wrapAdd(input logic [PTR_W-1:0] base,
                                               input logic [CNT_W-1:0] step);
    logic [CNT_W:0] sum;
    sum = {{(CNT_W + 1 - PTR_W){1'b0}}, base} + {1'b0, step};
    if (sum >= (CNT_W + 1)'(SLOTS)) sum = sum - (CNT_W + 1)'(SLOTS);
    return sum[PTR_W-1:0];
  endfunction

  // Request sizing: zero takes one slot, oversize is cut to the buffer.
  always_comb begin
    if (rsvUops == '0)                   capLen = CNT_W'(1);
    else if (rsvUops > UOP_W'(SLOTS))    capLen = CNT_W'(SLOTS);
    else                                 capLen = rsvUops[CNT_W-1:0];
  end

  assign rsvAvail  = (capLen <= freeQ);
  assign rsvAccept = rsvValid && rsvAvail;
  assign rsvToken  = tailQ;
  assign bufFull   = (freeQ == '0);
  assign bufEmpty  = (freeQ == CNT_W'(SLOTS));

  assign strb.tokWrite = rsvAccept;
  assign strb.exeMark  = exeValid && tokValid[exeToken];
  assign wrPos  = tailQ;
  assign wrLen  = capLen;
  assign exePos = exeToken;

  // In-order retire walk from the head, one candidate per lane.
  always_comb begin
    logic [PTR_W-1:0] pos;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] freed;
    logic             go;
    pos     = headQ;
    remain  = CNT_W'(SLOTS) - freeQ;
    freed   = '0;
    go      = tick;
    clrMask = '0;
    for (int k = 0; k < SLOTS; k++) begin
      len = tokLen[pos*CNT_W +: CNT_W];
      lanePos[k*PTR_W +: PTR_W] = pos;
      laneFire[k] = go && tokValid[pos] && tokExec[pos] && (len <= remain) &&
                    ((retireLimit == '0) || (CNT_W'(k) < retireLimit));
      if (laneFire[k]) begin
        clrMask[pos] = 1'b1;
        freed  = freed + len;
        remain = remain - len;
        pos    = wrapAdd(pos, len);
      end else begin
        go = 1'b0;
      end
    end
    headNext = pos;
    freedSum = freed;
  end

  // Frees are added before the reservation is taken away.
  assign freeSum = {1'b0, freeQ} + {1'b0, freedSum} -
                   (rsvAccept ? {1'b0, capLen} : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
      freeQ <= CNT_W'(SLOTS);
    end else begin
      headQ <= headNext;
      freeQ <= freeSum[CNT_W-1:0];
      if (rsvAccept) tailQ <= wrapAdd(tailQ, capLen);
    end
  end

endmodule

// File: rtl/rsc_token_table.sv
module rsc_token_table
  import rsc_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int IDX_W = 16,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rsc_strobe_t              strb,
  input  logic [PTR_W-1:0]         wrPos,
  input  logic [IDX_W-1:0]         wrIdx,
  input  logic [CNT_W-1:0]         wrLen,
  input  logic [PTR_W-1:0]         exePos,
  input  logic [SLOTS-1:0]         clrMask,
  input  logic [SLOTS*PTR_W-1:0]   lanePos,
  input  logic [SLOTS-1:0]         laneFire,
  output logic [SLOTS-1:0]         tokValid,
  output logic [SLOTS-1:0]         tokExec,
  output logic [SLOTS*CNT_W-1:0]   tokLen,
  output logic [SLOTS-1:0]         retValid,
  output logic [SLOTS*IDX_W-1:0]   retIndex
);

  logic [SLOTS*IDX_W-1:0] idxFlat;

  // One token record per slot position; only a token's first slot is live.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic             vQ, eQ;
    logic [IDX_W-1:0] iQ;
    logic [CNT_W-1:0] lQ;
    logic             hitWr, hitExe;

    assign hitWr  = strb.tokWrite && (wrPos == PTR_W'(s));
    assign hitExe = strb.exeMark && (exePos == PTR_W'(s));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vQ <= 1'b0;
        eQ <= 1'b0;
        iQ <= '0;
        lQ <= '0;
      end else if (hitWr) begin
        vQ <= 1'b1;
        eQ <= 1'b0;
        iQ <= wrIdx;
        lQ <= wrLen;
      end else if (clrMask[s]) begin
        vQ <= 1'b0;
        eQ <= 1'b0;
      end else if (hitExe) begin
        eQ <= 1'b1;
      end
    end

    assign tokValid[s] = vQ;
    assign tokExec[s]  = eQ;
    assign tokLen[s*CNT_W +: CNT_W]  = lQ;
    assign idxFlat[s*IDX_W +: IDX_W] = iQ;
  end

  // Registered retire lanes, lane 0 oldest.
  for (genvar k = 0; k < SLOTS; k++) begin : g_lane
    logic [PTR_W-1:0] lp;
    logic             rvQ;
    logic [IDX_W-1:0] riQ;

    assign lp = lanePos[k*PTR_W +: PTR_W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rvQ <= 1'b0;
        riQ <= '0;
      end else begin
        rvQ <= laneFire[k];
        riQ <= laneFire[k] ? idxFlat[lp*IDX_W +: IDX_W] : '0;
      end
    end

    assign retValid[k] = rvQ;
    assign retIndex[k*IDX_W +: IDX_W] = riQ;
  end

endmodule

// File: rtl/retire_slot_ctrl.sv
module retire_slot_ctrl
  import rsc_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int UOP_W = 8,
  parameter int IDX_W = 16,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tick,
  input  logic [CNT_W-1:0]       retireLimit,
  input  logic                   rsvValid,
  input  logic [UOP_W-1:0]       rsvUops,
  input  logic [IDX_W-1:0]       rsvIndex,
  output logic                   rsvAvail,
  output logic                   rsvAccept,
  output logic [PTR_W-1:0]       rsvToken,
  input  logic                   exeValid,
  input  logic [PTR_W-1:0]       exeToken,
  output logic [SLOTS-1:0]       retValid,
  output logic [SLOTS*IDX_W-1:0] retIndex,
  output logic                   bufFull,
  output logic                   bufEmpty
);

  rsc_strobe_t              strb;
  logic [PTR_W-1:0]         wrPos, exePos;
  logic [CNT_W-1:0]         wrLen;
  logic [SLOTS-1:0]         clrMask, laneFire, tokValid, tokExec;
  logic [SLOTS*PTR_W-1:0]   lanePos;
  logic [SLOTS*CNT_W-1:0]   tokLen;

  rsc_retire_ctrl #(.SLOTS(SLOTS), .UOP_W(UOP_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .retireLimit(retireLimit),
    .rsvValid(rsvValid), .rsvUops(rsvUops),
    .exeValid(exeValid), .exeToken(exeToken),
    .tokValid(tokValid), .tokExec(tokExec), .tokLen(tokLen),
    .strb(strb), .wrPos(wrPos), .wrLen(wrLen), .exePos(exePos),
    .clrMask(clrMask), .lanePos(lanePos), .laneFire(laneFire),
    .rsvAvail(rsvAvail), .rsvAccept(rsvAccept), .rsvToken(rsvToken),
    .bufFull(bufFull), .bufEmpty(bufEmpty)
  );

  rsc_token_table #(.SLOTS(SLOTS), .IDX_W(IDX_W)) i_table (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrPos(wrPos), .wrIdx(rsvIndex), .wrLen(wrLen), .exePos(exePos),
    .clrMask(clrMask), .lanePos(lanePos), .laneFire(laneFire),
    .tokValid(tokValid), .tokExec(tokExec), .tokLen(tokLen),
    .retValid(retValid), .retIndex(retIndex)
  );

endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int SLOTS = 16,
  parameter int UOP_W = 8,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               tick,
  input logic [CNT_W-1:0]   retireLimit,
  input logic               rsvValid,
  input logic [UOP_W-1:0]   rsvUops,
  input logic               rsvAccept,
  input logic [PTR_W-1:0]   rsvToken,
  input logic [SLOTS-1:0]   retValid,
  input logic               bufFull,
  input logic               bufEmpty
);

  assert_token_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rsvAccept && rsvUops != '0 && rsvUops <= UOP_W'(SLOTS)) |=>
      (int'(rsvToken) == (int'($past(rsvToken)) + int'($past(rsvUops))) % SLOTS));

  assert_zero_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rsvAccept && rsvUops == '0) |=>
      (int'(rsvToken) == (int'($past(rsvToken)) + 1) % SLOTS));

  assert_cap_fill_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rsvAccept && bufEmpty && rsvUops >= UOP_W'(SLOTS)) |=> bufFull);

  assert_reject_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rsvValid && !rsvAccept) |=> $stable(rsvToken));

  assert_empty_no_retire_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && bufEmpty) |=> (retValid == '0));

  assert_limit_cap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tick && retireLimit != '0) |=> ($countones(retValid) <= int'($past(retireLimit))));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> (retValid == '0));

  assert_lanes_packed_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((retValid & (retValid + SLOTS'(1))) == '0));

  assert_full_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(bufFull && bufEmpty));

endmodule

bind retire_slot_ctrl rsc_checker #(.SLOTS(SLOTS), .UOP_W(UOP_W)) i_rscChecker (
  .clk(clk), .rstN(rstN), .tick(tick), .retireLimit(retireLimit),
  .rsvValid(rsvValid), .rsvUops(rsvUops), .rsvAccept(rsvAccept),
  .rsvToken(rsvToken), .retValid(retValid),
  .bufFull(bufFull), .bufEmpty(bufEmpty)
);

// File: tb/test_retire_slot_ctrl.sv
`timescale 1ns/1ps
module test_retire_slot_ctrl;

  localparam int SLOTS = 16;
  localparam int UOP_W = 8;
  localparam int IDX_W = 16;
  localparam int PTR_W = 4;
  localparam int CNT_W = 5;

  logic                   clk = 1'b0;
  logic                   rstN;
  logic                   tick;
  logic [CNT_W-1:0]       retireLimit;
  logic                   rsvValid;
  logic [UOP_W-1:0]       rsvUops;
  logic [IDX_W-1:0]       rsvIndex;
  logic                   rsvAvail, rsvAccept;
  logic [PTR_W-1:0]       rsvToken;
  logic                   exeValid;
  logic [PTR_W-1:0]       exeToken;
  logic [SLOTS-1:0]       retValid;
  logic [SLOTS*IDX_W-1:0] retIndex;
  logic                   bufFull, bufEmpty;

  always #2 clk = ~clk;  // 250 MHz

  retire_slot_ctrl #(.SLOTS(SLOTS), .UOP_W(UOP_W), .IDX_W(IDX_W)) i_retire_slot_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .retireLimit(retireLimit),
    .rsvValid(rsvValid), .rsvUops(rsvUops), .rsvIndex(rsvIndex),
    .rsvAvail(rsvAvail), .rsvAccept(rsvAccept), .rsvToken(rsvToken),
    .exeValid(exeValid), .exeToken(exeToken),
    .retValid(retValid), .retIndex(retIndex),
    .bufFull(bufFull), .bufEmpty(bufEmpty)
  );

  typedef struct packed {
    int rsv; int uops; int idx; int exe; int exeTok; int tck; int lim;
    int eAcc; int eTok; int eCnt; int eRet0; int eEmpty; int eFull;
  } vec_t;

  // Stimulus and expectations, one cycle per row.
  localparam vec_t VECS [17] = '{
    '{1,  3, 100, 0, 0, 0, 0,  1, 0,  0,   0, 0, 0},  // R2 first token at 0
    '{1,  0, 101, 0, 0, 0, 0,  1, 3,  0,   0, 0, 0},  // R3 zero takes one slot
    '{1,  5, 102, 1, 3, 0, 0,  1, 4,  0,   0, 0, 0},  // R5 mark younger token
    '{0,  0,   0, 0, 0, 1, 0,  0, 9,  0,   0, 0, 0},  // R6 head not executed
    '{0,  0,   0, 1, 0, 0, 0,  0, 9,  0,   0, 0, 0},
    '{0,  0,   0, 0, 0, 1, 0,  0, 9,  2, 100, 0, 0},  // R6 two retire, stop at 102
    '{1, 20, 103, 0, 0, 0, 0,  0, 9,  0,   0, 0, 0},  // R3/R4 cap 16 > free 11
    '{1, 11, 104, 1, 5, 0, 0,  1, 9,  0,   0, 0, 1},  // R5 non-start ignored, wrap
    '{0,  0,   0, 0, 0, 1, 0,  0, 4,  0,   0, 0, 1},  // R5 nothing retires
    '{1,  1, 105, 1, 4, 0, 0,  0, 4,  0,   0, 0, 1},  // R4 full rejects
    '{0,  0,   0, 1, 9, 1, 1,  0, 4,  1, 102, 0, 0},  // R7 limit one
    '{1,  5, 106, 0, 0, 1, 0,  1, 4,  1, 104, 0, 0},  // R10 reserve with retire
    '{0,  0,   0, 1, 4, 0, 0,  0, 9,  0,   0, 0, 0},
    '{0,  0,   0, 0, 0, 1, 0,  0, 9,  1, 106, 1, 0},  // R9 back to empty
    '{1, 16, 107, 0, 0, 0, 0,  1, 9,  0,   0, 0, 1},  // R3 whole buffer
    '{0,  0,   0, 1, 9, 0, 0,  0, 9,  0,   0, 0, 1},
    '{0,  0,   0, 0, 0, 1, 0,  0, 9,  1, 107, 1, 0}   // R9 full-size token freed
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int laneIdx(input int k);
    return int'(retIndex[k*IDX_W +: IDX_W]);
  endfunction

  task automatic idle();
    tick = 1'b0; retireLimit = '0; rsvValid = 1'b0; rsvUops = '0;
    rsvIndex = '0; exeValid = 1'b0; exeToken = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reserve(input int uops, input int idx);
    rsvValid = 1'b1; rsvUops = UOP_W'(uops); rsvIndex = IDX_W'(idx);
    step();
    idle();
  endtask

  task automatic markExe(input int tok);
    exeValid = 1'b1; exeToken = PTR_W'(tok);
    step();
    idle();
  endtask

  task automatic doTick(input int lim);
    tick = 1'b1; retireLimit = CNT_W'(lim);
    step();
    idle();
  endtask

  initial begin
    vec_t v;
    idle();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 empty after reset", int'(bufEmpty), 1);
    chk("R1 full after reset", int'(bufFull), 0);
    chk("R1 first token", int'(rsvToken), 0);
    chk("R1 lanes idle", int'(retValid), 0);
    @(negedge clk);

    for (int i = 0; i < 17; i++) begin
      v = VECS[i];
      rsvValid = v.rsv[0]; rsvUops = UOP_W'(v.uops); rsvIndex = IDX_W'(v.idx);
      exeValid = v.exe[0]; exeToken = PTR_W'(v.exeTok);
      tick = v.tck[0]; retireLimit = CNT_W'(v.lim);
      #1;
      chk($sformatf("R4 row %0d accept", i), int'(rsvAccept), v.eAcc);
      chk($sformatf("R2 row %0d token", i), int'(rsvToken), v.eTok);
      step();
      idle();
      chk($sformatf("R6 row %0d retire count", i), $countones(retValid), v.eCnt);
      if (v.eCnt > 0) chk($sformatf("R8 row %0d lane0 index", i), laneIdx(0), v.eRet0);
      chk($sformatf("R9 row %0d empty", i), int'(bufEmpty), v.eEmpty);
      chk($sformatf("R9 row %0d full", i), int'(bufFull), v.eFull);
    end

    // R7: limit of two, then unlimited (buffer empty, head and tail at 9)
    for (int t = 0; t < 4; t++) begin
      chk("R2 single-slot token", int'(rsvToken), 9 + t);
      reserve(1, 200 + t);
    end
    for (int t = 0; t < 4; t++) markExe(9 + t);
    doTick(2);
    chk("R7 limit two count", $countones(retValid), 2);
    chk("R8 lane0 oldest", laneIdx(0), 200);
    chk("R8 lane1 next", laneIdx(1), 201);
    doTick(0);
    chk("R7 unlimited count", $countones(retValid), 2);
    chk("R8 lane0 after limit", laneIdx(0), 202);
    chk("R8 lane1 after limit", laneIdx(1), 203);
    chk("R9 empty after drain", int'(bufEmpty), 1);

    // R10: reserve 4 while a 12-slot token retires (head and tail at 13)
    reserve(12, 400);
    markExe(13);
    rsvValid = 1'b1; rsvUops = 8'd4; rsvIndex = 16'd401;
    tick = 1'b1; retireLimit = '0;
    #1;
    chk("R10 accept against start free", int'(rsvAccept), 1);
    step();
    idle();
    chk("R10 retire alongside reserve", laneIdx(0), 400);
    rsvUops = 8'd12;
    #1;
    chk("R10 twelve free", int'(rsvAvail), 1);
    rsvUops = 8'd13;
    #1;
    chk("R10 not thirteen free", int'(rsvAvail), 0);
    idle();
    reserve(12, 402);
    chk("R10 full after refill", int'(bufFull), 1);

    // R1: reset from a busy state
    rstN = 1'b0;
    step();
    rstN = 1'b1;
    #1;
    chk("R1 empty after mid reset", int'(bufEmpty), 1);
    chk("R1 token after mid reset", int'(rsvToken), 0);
    chk("R1 lanes after mid reset", int'(retValid), 0);
    @(negedge clk);

    // R3 and R5 from empty
    rsvValid = 1'b1; rsvUops = 8'd0; rsvIndex = 16'd300;
    #1;
    chk("R3 zero count accepted", int'(rsvAccept), 1);
    step();
    idle();
    chk("R3 zero count advances one", int'(rsvToken), 1);
    rsvUops = 8'd40;
    #1;
    chk("R3 oversize capped to 16 over 15 free", int'(rsvAvail), 0);
    rsvUops = 8'd15;
    #1;
    chk("R3 fifteen fits", int'(rsvAvail), 1);
    idle();
    markExe(1);
    doTick(0);
    chk("R5 mark at free slot ignored", $countones(retValid), 0);
    markExe(0);
    doTick(0);
    chk("R5 marked token retires", $countones(retValid), 1);
    chk("R8 retired index", laneIdx(0), 300);
    chk("R9 empty again", int'(bufEmpty), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule